// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns raw, asynchronous interrupt pins into clean interrupt requests for a processor core. It serves one dedicated interrupt pin and two groups of pin-change inputs. Group A has eight pins. Group B has seven. Every pin passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with the value it had one cycle earlier.

The dedicated pin has a 2-bit sense field that selects one of four modes: low level, any change, falling edge or rising edge. In low-level mode the request follows the synchronized pin and is never stored. In the three edge modes a matching edge sets a sticky flag. Each pin-change group ORs the toggles of the pins its mask lets through into one sticky group flag. A flag stays set until its acknowledge input clears it. Every request leaves the block only when its own enable bit and the global interrupt-enable input are both high.

Software reaches the control bits through a small register port with a synchronous write and a combinational read:

| Address | Contents |
|---|---|
| 0 | Control byte: sense field in bits 1:0 (00 low level, 01 any change, 10 falling, 11 rising), dedicated-pin enable in bit 2, group A enable in bit 3, group B enable in bit 4 |
| 1 | Group A mask, bit n for `pc_a[n]` |
| 2 | Group B mask, bit n for `pc_b[n]`, bit 7 reserved |
| 3 | Reads as zero |

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every control, mask and enable bit reads as zero at addresses 0, 1 and 2, and `irq_ext` and `irq_pc` are low.
- R2: With sense 00, `irq_ext` is high exactly while the synchronized pin is low. It rises two rising clock edges after the pin goes low, it falls two edges after the pin goes high, and it is never latched.
- R3: With sense 01, any change of `ext_pin` sets the dedicated flag.
- R4: With sense 10 only a falling edge sets the dedicated flag, and with sense 11 only a rising edge sets it. The opposite edge has no effect.
- R5: `irq_ext` is high only when the dedicated flag (or the low level) is present, the enable bit 2 at address 0 is set, and `gie` is high. Dropping either gate masks a pending flag without clearing it.
- R6: A toggle on a pin whose mask bit is set sets that group's flag. A toggle on a pin whose mask bit is clear does not.
- R7: `irq_pc[g]` is high only while group g's flag is set, its enable bit (bit 3 for A, bit 4 for B) is set, and `gie` is high.
- R8: Writes to bit 7 at address 2 and bits 7:5 at address 0 are dropped, and these bits read as zero.
- R9: A flag holds until its acknowledge is high at a clock edge. If a new event arrives at that same edge, the flag stays set.
- R10: Setting a mask bit for a pin that already sits at a new level does not by itself raise a group request.
- R11: In an edge mode, a pin change driven between clock edges raises `irq_ext` right after the third following rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (2) | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| gie | input | 1 | Global interrupt enable |
| ext_pin | input | 1 | Dedicated interrupt pin, asynchronous |
| pc_a | input | A_PINS (8) | Pin-change group A, asynchronous |
| pc_b | input | B_PINS (7) | Pin-change group B, asynchronous |
| ack_ext | input | 1 | Clears the dedicated flag |
| ack_pc | input | 2 | Clears the group flags (bit 0 for A, bit 1 for B) |
| irq_ext | output | 1 | Dedicated pin request |
| irq_pc | output | 2 | Group requests (bit 0 for A, bit 1 for B) |

## Verification
The assertions assume three things about the inputs:
- Reset is applied before any request is examined.
- `ack_ext` and `ack_pc` are single-cycle pulses.
- Every pin level lasts at least one full clock period, so the synchronizer sees every edge.

The bench drives all inputs on the falling clock edge and holds each pin level for two cycles or more. It pulses an acknowledge for exactly one rising edge, and it samples the outputs on falling edges. In one test the bench lines up an acknowledge with the cycle in which a new edge event is decoded, to exercise the case where the new event wins.

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense #(
  parameter int A_PINS = 8,
  parameter int B_PINS = 7,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              gie,
  input  logic              ext_pin,
  input  logic [A_PINS-1:0] pc_a,
  input  logic [B_PINS-1:0] pc_b,
  input  logic              ack_ext,
  input  logic [1:0]        ack_pc,
  output logic              irq_ext,
  output logic [1:0]        irq_pc
);
  localparam int NP = 1 + A_PINS + B_PINS;

  logic [NP-1:0]     s1, s2, hist;
  logic [1:0]        sense;
  logic              ext_en;
  logic [1:0]        grp_en;
  logic [A_PINS-1:0] mask_a;
  logic [B_PINS-1:0] mask_b;
  logic              ext_flag;
  logic [1:0]        pc_flag;

  wire [NP-1:0] chg = s2 ^ hist;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; hist <= '0;
    end else begin
      s1   <= {pc_b, pc_a, ext_pin};
      s2   <= s1;
      hist <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sense <= '0; ext_en <= 1'b0; grp_en <= '0; mask_a <= '0; mask_b <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AW'(0): {grp_en, ext_en, sense} <= reg_wdata[4:0];
        AW'(1): mask_a <= reg_wdata[A_PINS-1:0];
        AW'(2): mask_b <= reg_wdata[B_PINS-1:0];
        default: ;
      endcase
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata[4:0] = {grp_en, ext_en, sense};
      AW'(1): reg_rdata[A_PINS-1:0] = mask_a;
      AW'(2): reg_rdata[B_PINS-1:0] = mask_b;
      default: ;
    endcase
  end

  wire ext_ev = chg[0] & ((sense == 2'b01) |
                          (sense == 2'b10 & ~s2[0]) |
                          (sense == 2'b11 &  s2[0]));

  wire [1:0] grp_ev = { |(chg[NP-1:A_PINS+1] & mask_b),
                        |(chg[A_PINS:1]      & mask_a) };

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_flag <= 1'b0;
      pc_flag  <= '0;
    end else begin
      ext_flag <= ext_ev | (ext_flag & ~ack_ext);
      pc_flag  <= grp_ev | (pc_flag & ~ack_pc);
    end

  wire ext_req = (sense == 2'b00) ? ~s2[0] : ext_flag;

  assign irq_ext = gie & ext_en & ext_req;
  assign irq_pc  = {2{gie}} & grp_en & pc_flag;
endmodule

// File: rtl/ext_irq_sense_chk.sv
`timescale 1ns/1ps
module ext_irq_sense_chk #(
  parameter int AW     = 2,
  parameter int B_PINS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gie,
  input logic          ext_en,
  input logic [1:0]    grp_en,
  input logic [1:0]    sense,
  input logic          sync_ext,
  input logic          ext_ev,
  input logic          ext_flag,
  input logic          ack_ext,
  input logic          irq_ext,
  input logic [1:0]    irq_pc,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_rdata
);
  assert_ext_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext |-> (gie && ext_en));

  assert_grp0_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pc[0] |-> (gie && grp_en[0]));

  assert_grp1_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pc[1] |-> (gie && grp_en[1]));

  assert_level_unlatched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == 2'b00 && sync_ext) |-> !irq_ext);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ext && !ext_ev) |=> !ext_flag);

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ev |=> ext_flag);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag && !ack_ext) |=> ext_flag);

  generate if (B_PINS < 8) begin : g_rsv
    assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == AW'(2)) |-> !reg_rdata[7]);
  end endgenerate
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.AW(AW), .B_PINS(B_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ext_en(ext_en), .grp_en(grp_en),
  .sense(sense), .sync_ext(s2[0]), .ext_ev(ext_ev), .ext_flag(ext_flag),
  .ack_ext(ack_ext), .irq_ext(irq_ext), .irq_pc(irq_pc),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_ext_irq_sense.sv
`timescale 1ns/1ps
module tb_ext_irq_sense;
  localparam time CLK = 20ns;

  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       gie = 0, ext_pin = 0, ack_ext = 0;
  logic [7:0] pc_a = 0;
  logic [6:0] pc_b = 0;
  logic [1:0] ack_pc = 0;
  logic       irq_ext;
  logic [1:0] irq_pc;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  ext_irq_sense dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .ext_pin(ext_pin),
    .pc_a(pc_a), .pc_b(pc_b), .ack_ext(ack_ext), .ack_pc(ack_pc),
    .irq_ext(irq_ext), .irq_pc(irq_pc)
  );

  // {mode[1:0], start, end, expected}
  localparam logic [4:0] VEC [8] = '{
    5'b01_0_1_1, 5'b01_1_0_1, 5'b10_1_0_1, 5'b10_0_1_0,
    5'b11_0_1_1, 5'b11_1_0_0, 5'b01_0_0_0, 5'b11_1_1_0
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic ack_e();
    ack_ext = 1; step(1); ack_ext = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a); #1;
      chk("R1 reg", reg_rdata, 0);
    end
    chk("R1 irq_ext", irq_ext, 0);
    chk("R1 irq_pc", irq_pc, 0);
    step(1);
    gie = 1;

    // R3 / R4 edge-mode table
    for (int i = 0; i < 8; i++) begin
      logic [4:0] v;
      v = VEC[i];
      wr(0, {5'b00001, v[4:3]});
      ext_pin = v[2]; step(4); ack_e(); step(1);
      ext_pin = v[1]; step(4);
      chk((v[4:3] == 2'b01) ? "R3 any change" : "R4 edge select", irq_ext, v[0]);
      ack_e(); step(1);
    end

    // R2 level mode
    wr(0, 8'h04);
    ext_pin = 1; step(3);
    ext_pin = 0; step(1);
    chk("R2 level one edge", irq_ext, 0);
    step(1);
    chk("R2 level asserted", irq_ext, 1);
    ext_pin = 1; step(2);
    chk("R2 level not latched", irq_ext, 0);

    // R11 latency in rising mode
    wr(0, 8'h07);
    ext_pin = 0; step(4); ack_e(); step(1);
    ext_pin = 1; step(2);
    chk("R11 before third edge", irq_ext, 0);
    step(1);
    chk("R11 at third edge", irq_ext, 1);

    // R5 gating
    gie = 0; #1;
    chk("R5 gie low", irq_ext, 0);
    gie = 1; #1;
    chk("R5 gie high", irq_ext, 1);
    wr(0, 8'h03);
    chk("R5 enable low", irq_ext, 0);
    wr(0, 8'h07);
    chk("R5 flag kept", irq_ext, 1);

    // R9 acknowledge and collision
    ack_e();
    chk("R9 ack clears", irq_ext, 0);
    wr(0, 8'h05);
    ext_pin = 0; step(3);
    chk("R9 flag set", irq_ext, 1);
    ext_pin = 1; step(2);
    ack_ext = 1; step(1); ack_ext = 0;
    chk("R9 event wins over ack", irq_ext, 1);
    step(2);
    chk("R9 sticky", irq_ext, 1);
    ack_e();
    chk("R9 cleared", irq_ext, 0);

    // R6 pin-change group A
    wr(0, 8'h08);
    wr(1, 8'h05);
    pc_a = 8'h02; step(4);
    chk("R6 masked pin ignored", irq_pc[0], 0);
    pc_a = 8'h06; step(4);
    chk("R6 unmasked pin", irq_pc[0], 1);
    ack_pc = 2'b01; step(1); ack_pc = 0;
    chk("R9 group ack", irq_pc, 0);

    // R7 group gating
    wr(2, 8'h40);
    pc_b = 7'h40; step(4);
    chk("R7 group disabled", irq_pc, 0);
    wr(0, 8'h18);
    chk("R7 group enabled", irq_pc, 2'b10);
    gie = 0; #1;
    chk("R7 gie low", irq_pc, 0);
    gie = 1;
    ack_pc = 2'b10; step(1); ack_pc = 0;

    // R10 mask change without toggle
    pc_a = 8'h0E; step(4);
    chk("R10 masked toggle", irq_pc[0], 0);
    wr(1, 8'h0D); step(4);
    chk("R10 mask set no event", irq_pc[0], 0);

    // R8 reserved bits
    wr(2, 8'hFF);
    reg_addr = 2; #1;
    chk("R8 group B bit7", reg_rdata, 8'h7F);
    wr(0, 8'hFF);
    reg_addr = 0; #1;
    chk("R8 control upper bits", reg_rdata, 8'h1F);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule